// File: doc/BRIEF.md
# External Clock Input Qualifier

This block watches a slow reference clock that arrives on a pin configured as an input. It decides whether a timekeeping counter may use that clock. The raw input is brought into a fast system-clock domain through a flip-flop synchronizer, and its rising edges are turned into single-cycle pulses. The time between edges is counted in system-clock cycles and compared with an acceptance window. The window is derived at elaboration from the system-clock frequency and from the nominal rate chosen by a two-bit selector.

A sticky "signal lost" flag records three kinds of trouble:
- the input is not selected;
- the input stops toggling for longer than twice its nominal period;
- a measured period falls outside a ±0.8 % band around the nominal value.

The flag is cleared only by a clear strobe. The timekeeper advances on the tick output. That output pulses once per synchronized rising edge, but only while the input is selected and the flag is low.

A three-state controller drives the monitor. The states are:
- ST_OFF: input deselected; the measurement is held in restart.
- ST_ARM: waiting for the first edge of a fresh measurement.
- ST_RUN: measuring.

The transitions are:
- *enable*: ST_OFF to ST_ARM when the select goes high.
- *deselect*: any state to ST_OFF when the select goes low.
- *first edge*: ST_ARM to ST_RUN.
- *stall*: ST_ARM or ST_RUN to ST_ARM when the gap timer expires; this also raises the flag.
- *reselect*: ST_ARM or ST_RUN to ST_ARM when the rate selector changes; this only restarts the measurement.
- *drift*: ST_RUN to itself when a finished window is out of tolerance; this raises the flag unless drift detection is inhibited.

Top module: `ext_clk_qualifier`

## Requirements
- R1: The rate selector picks the nominal input rate: 00 selects SLOW_HZ (1 Hz by default), 01 selects MID_A_HZ (50 Hz), 10 selects MID_B_HZ (60 Hz) and 11 selects FAST_HZ (32.768 kHz). A measured period of at least floor(N·0.992) and at most floor(N·1.008) system cycles, where N = SYS_HZ/rate, leaves the flag low.
- R2: While the select input is 0, the flag reads 1 from the next clock on. In that state use_ext and the tick are 0, and a clear strobe has no effect.
- R3: If no synchronized rising edge arrives for STALL_MULT (2) nominal periods while selected, the flag is set; a shorter gap does not set it.
- R4: On the lower three rate settings, every edge-to-edge period is checked. A period outside the R1 window sets the flag in the cycle after the edge that closes it.
- R5: On the 11 setting, one verdict covers FAST_AVG (256) consecutive periods, and the window of R1 is scaled by FAST_AVG. Individual periods may therefore deviate as long as their total is inside the window.
- R6: The flag is 1 after reset and stays 1 until a clear strobe arrives while the input is selected. A one-cycle clear strobe drops it to 0 in the next cycle, unless a set condition occurs in the same cycle.
- R7: A clear strobe given while the last verdict was out of tolerance inhibits drift detection, although stall detection stays active. The inhibit ends when the select goes to 0 or at reset.
- R8: use_ext equals select AND NOT flag. ext_tick is a one-cycle pulse for each synchronized rising edge while use_ext is 1, and it is 0 otherwise.
- R9: Changing the rate selector while selected restarts the measurement without setting the flag. The first period after the change is measured against the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | 1 selects the pin as a clock input |
| rate_sel | input | 2 | Nominal rate selector (see R1) |
| clk_in | input | 1 | Raw external clock, asynchronous |
| sig_lost_clr | input | 1 | One-cycle clear strobe for the flag |
| sig_lost | output | 1 | Sticky signal-lost flag |
| use_ext | output | 1 | External clock may advance time |
| ext_tick | output | 1 | One pulse per accepted input edge |

## Verification
The bench probes each window just inside and just outside its edges. A design that rounds the limits the wrong way, or swaps two rate codes, flags a good clock or passes a bad one. On the fast setting it drives a 6/7-cycle mix whose individual periods miss the window but whose 256-period total lands inside it; a meter that judges single periods raises the flag there. It times the stall check on both sides of the two-period gap, and it changes the rate in mid-stream so that a meter which does not restart compares a stale period against the new window. It also clears the flag after a bad verdict to confirm that drift is then ignored while a stall is still caught, and that deselecting the input releases the inhibit.

// File: rtl/xcq_pkg.sv
package xcq_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } mon_state_e;

    // Cycles in `periods` input periods, scaled by scale_ppm / 1e6, rounded down.
    function automatic longint unsigned bound_cycles(
        input longint unsigned sys_hz,
        input longint unsigned rate_hz,
        input longint unsigned periods,
        input longint unsigned scale_ppm
    );
        return (sys_hz * periods * scale_ppm) / (rate_hz * 64'd1_000_000);
    endfunction

    function automatic longint unsigned max4(
        input longint unsigned a,
        input longint unsigned b,
        input longint unsigned c,
        input longint unsigned d
    );
        longint unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/xcq_sync_edge.sv
module xcq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    if (g == 0) chain[g] <= async_in;
                    else        chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R8

endmodule

// File: rtl/xcq_period_meter.sv
module xcq_period_meter #(
    parameter int unsigned SYS_HZ     = 50_000_000,
    parameter int unsigned SLOW_HZ    = 1,
    parameter int unsigned MID_A_HZ   = 50,
    parameter int unsigned MID_B_HZ   = 60,
    parameter int unsigned FAST_HZ    = 32_768,
    parameter int unsigned FAST_AVG   = 256,
    parameter int unsigned TOL_PPM    = 8_000,
    parameter int unsigned STALL_MULT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       rise,
    input  logic [1:0] rate,
    output logic       win_done,
    output logic       win_ok,
    output logic       gap_expired
);
    import xcq_pkg::*;

    localparam longint unsigned LOW_SC  = 64'd1_000_000 - TOL_PPM;
    localparam longint unsigned HIGH_SC = 64'd1_000_000 + TOL_PPM;

    localparam longint unsigned LO0 = bound_cycles(SYS_HZ, SLOW_HZ,  1, LOW_SC);
    localparam longint unsigned HI0 = bound_cycles(SYS_HZ, SLOW_HZ,  1, HIGH_SC);
    localparam longint unsigned LO1 = bound_cycles(SYS_HZ, MID_A_HZ, 1, LOW_SC);
    localparam longint unsigned HI1 = bound_cycles(SYS_HZ, MID_A_HZ, 1, HIGH_SC);
    localparam longint unsigned LO2 = bound_cycles(SYS_HZ, MID_B_HZ, 1, LOW_SC);
    localparam longint unsigned HI2 = bound_cycles(SYS_HZ, MID_B_HZ, 1, HIGH_SC);
    localparam longint unsigned LO3 = bound_cycles(SYS_HZ, FAST_HZ, FAST_AVG, LOW_SC);
    localparam longint unsigned HI3 = bound_cycles(SYS_HZ, FAST_HZ, FAST_AVG, HIGH_SC);

    localparam longint unsigned TO0 = (64'(STALL_MULT) * SYS_HZ) / SLOW_HZ;
    localparam longint unsigned TO1 = (64'(STALL_MULT) * SYS_HZ) / MID_A_HZ;
    localparam longint unsigned TO2 = (64'(STALL_MULT) * SYS_HZ) / MID_B_HZ;
    localparam longint unsigned TO3 = (64'(STALL_MULT) * SYS_HZ) / FAST_HZ;

    localparam longint unsigned MAX_HI = max4(HI0, HI1, HI2, HI3);
    localparam longint unsigned MAX_TO = max4(TO0, TO1, TO2, TO3);
    localparam int CNT_W = $clog2(MAX_HI + 2);
    localparam int GAP_W = $clog2(MAX_TO + 2);
    localparam int EW    = (FAST_AVG > 1) ? $clog2(FAST_AVG) : 1;

    logic [CNT_W-1:0] per_cnt;
    logic [GAP_W-1:0] gap;
    logic [EW-1:0]    edge_idx;
    logic             started;

    logic [CNT_W-1:0] lo_sel, hi_sel;
    logic [GAP_W-1:0] to_sel;
    logic [EW-1:0]    last_idx;

    always_comb begin
        unique case (rate)
            2'b00: begin lo_sel = CNT_W'(LO0); hi_sel = CNT_W'(HI0); to_sel = GAP_W'(TO0); last_idx = '0; end
            2'b01: begin lo_sel = CNT_W'(LO1); hi_sel = CNT_W'(HI1); to_sel = GAP_W'(TO1); last_idx = '0; end
            2'b10: begin lo_sel = CNT_W'(LO2); hi_sel = CNT_W'(HI2); to_sel = GAP_W'(TO2); last_idx = '0; end
            2'b11: begin lo_sel = CNT_W'(LO3); hi_sel = CNT_W'(HI3); to_sel = GAP_W'(TO3); last_idx = EW'(FAST_AVG - 1); end
        endcase
    end

    assign win_done    = rise & started & (edge_idx == last_idx);
    assign win_ok      = (per_cnt >= lo_sel) && (per_cnt <= hi_sel);
    assign gap_expired = (gap >= to_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started  <= 1'b0;
            per_cnt  <= '0;
            gap      <= '0;
            edge_idx <= '0;
        end else if (restart) begin
            started  <= 1'b0;
            per_cnt  <= '0;
            gap      <= '0;
            edge_idx <= '0;
        end else begin
            if (rise)            gap <= '0;
            else if (gap != '1)  gap <= gap + GAP_W'(1);

            if (rise) begin
                started <= 1'b1;
                if (!started || edge_idx == last_idx) begin
                    per_cnt  <= CNT_W'(1);
                    edge_idx <= '0;
                end else begin
                    if (per_cnt != '1) per_cnt <= per_cnt + CNT_W'(1);
                    edge_idx <= edge_idx + EW'(1);
                end
            end else if (started && per_cnt != '1) begin
                per_cnt <= per_cnt + CNT_W'(1);
            end
        end
    end

    AST_GAP_CLEARED_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (rise && !restart) |=> !gap_expired); // R3

endmodule

// File: rtl/xcq_flag_ctrl.sv
module xcq_flag_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [1:0] rate,
    input  logic       clr,
    input  logic       rise,
    input  logic       win_done,
    input  logic       win_ok,
    input  logic       gap_expired,
    output logic       restart,
    output logic       lost
);
    import xcq_pkg::*;

    mon_state_e state, state_nx;
    logic [1:0] rate_q;
    logic       rate_chg;
    logic       bad_q;
    logic       inhibit_q;
    logic       set_stall;
    logic       set_drift;

    assign rate_chg = (rate != rate_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        restart   = 1'b0;
        set_stall = 1'b0;
        set_drift = 1'b0;
        unique case (state)
            ST_OFF: begin
                restart = 1'b1;
                if (sel) state_nx = ST_ARM;
            end
            ST_ARM: begin
                if (!sel) begin
                    restart  = 1'b1;
                    state_nx = ST_OFF;
                end else if (gap_expired) begin
                    restart   = 1'b1;
                    set_stall = 1'b1;
                end else if (rate_chg) begin
                    restart = 1'b1;
                end else if (rise) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!sel) begin
                    restart  = 1'b1;
                    state_nx = ST_OFF;
                end else if (gap_expired) begin
                    restart   = 1'b1;
                    set_stall = 1'b1;
                    state_nx  = ST_ARM;
                end else if (rate_chg) begin
                    restart  = 1'b1;
                    state_nx = ST_ARM;
                end else if (win_done && !win_ok && !inhibit_q) begin
                    set_drift = 1'b1;
                end
            end
            default: begin
                restart  = 1'b1;
                state_nx = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost      <= 1'b1;
            bad_q     <= 1'b0;
            inhibit_q <= 1'b0;
            rate_q    <= 2'b00;
        end else begin
            rate_q <= rate;
            if (!sel) begin
                lost      <= 1'b1;
                bad_q     <= 1'b0;
                inhibit_q <= 1'b0;
            end else begin
                if (set_stall || set_drift) lost <= 1'b1;
                else if (clr)               lost <= 1'b0;

                if (restart)       bad_q <= 1'b0;
                else if (win_done) bad_q <= !win_ok;

                if (clr && bad_q && !(set_stall || set_drift)) inhibit_q <= 1'b1;
            end
        end
    end

    AST_DESELECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !sel |=> lost); // R2
    AST_STALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (sel && gap_expired) |=> lost); // R3
    AST_DRIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (sel && state == ST_RUN && win_done && !win_ok && !inhibit_q && !rate_chg && !gap_expired) |=> lost); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (lost && !clr) |=> lost); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (sel && clr && !gap_expired && !win_done) |=> !lost); // R6
    AST_INHIBIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !sel |=> !inhibit_q); // R7

endmodule

// File: rtl/ext_clk_qualifier.sv
module ext_clk_qualifier #(
    parameter int unsigned SYS_HZ      = 50_000_000,
    parameter int unsigned SLOW_HZ     = 1,
    parameter int unsigned MID_A_HZ    = 50,
    parameter int unsigned MID_B_HZ    = 60,
    parameter int unsigned FAST_HZ     = 32_768,
    parameter int unsigned FAST_AVG    = 256,
    parameter int unsigned TOL_PPM     = 8_000,
    parameter int unsigned STALL_MULT  = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_sel,
    input  logic [1:0] rate_sel,
    input  logic       clk_in,
    input  logic       sig_lost_clr,
    output logic       sig_lost,
    output logic       use_ext,
    output logic       ext_tick
);
    logic rise;
    logic restart;
    logic win_done;
    logic win_ok;
    logic gap_expired;

    xcq_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (clk_in),
        .rise     (rise)
    );

    xcq_period_meter #(
        .SYS_HZ    (SYS_HZ),
        .SLOW_HZ   (SLOW_HZ),
        .MID_A_HZ  (MID_A_HZ),
        .MID_B_HZ  (MID_B_HZ),
        .FAST_HZ   (FAST_HZ),
        .FAST_AVG  (FAST_AVG),
        .TOL_PPM   (TOL_PPM),
        .STALL_MULT(STALL_MULT)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .rise       (rise),
        .rate       (rate_sel),
        .win_done   (win_done),
        .win_ok     (win_ok),
        .gap_expired(gap_expired)
    );

    xcq_flag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (ext_sel),
        .rate       (rate_sel),
        .clr        (sig_lost_clr),
        .rise       (rise),
        .win_done   (win_done),
        .win_ok     (win_ok),
        .gap_expired(gap_expired),
        .restart    (restart),
        .lost       (sig_lost)
    );

    assign use_ext  = ext_sel & ~sig_lost;
    assign ext_tick = rise & use_ext;

endmodule

// File: tb/ext_clk_qualifier_tb.sv
module ext_clk_qualifier_tb;

    // Scaled configuration: slow nominal rate raised to 100 Hz so runs stay short.
    localparam int unsigned SYS_HZ  = 200_000;
    localparam int unsigned SLOW_HZ = 100;

    typedef struct packed {
        logic [1:0] rate;
        int         per;      // 0 = fast-mode 6/7 mix averaging inside the window
        int         nper;
        logic       exp_lost;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 2000,   2, 1'b0},
        '{2'b00, 2040,   2, 1'b1},
        '{2'b01, 4000,   2, 1'b0},
        '{2'b01, 3960,   2, 1'b1},
        '{2'b10, 3333,   2, 1'b0},
        '{2'b10, 3380,   2, 1'b1},
        '{2'b11, 0,    260, 1'b0},
        '{2'b11, 6,    260, 1'b1},
        '{2'b01, 4020,   2, 1'b0},
        '{2'b00, 1990,   2, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_sel = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       clk_in = 1'b0;
    logic       sig_lost_clr = 1'b0;
    logic       sig_lost;
    logic       use_ext;
    logic       ext_tick;

    int  total = 0;
    int  bad = 0;
    int  tick_seen = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) if (ext_tick) tick_seen <= tick_seen + 1;

    ext_clk_qualifier #(
        .SYS_HZ (SYS_HZ),
        .SLOW_HZ(SLOW_HZ)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_sel     (ext_sel),
        .rate_sel    (rate_sel),
        .clk_in      (clk_in),
        .sig_lost_clr(sig_lost_clr),
        .sig_lost    (sig_lost),
        .use_ext     (use_ext),
        .ext_tick    (ext_tick)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_clr();
        sig_lost_clr = 1'b1;
        cyc(1);
        sig_lost_clr = 1'b0;
    endtask

    task automatic start(input logic [1:0] r);
        ext_sel = 1'b0;
        cyc(3);
        rate_sel = r;
        ext_sel = 1'b1;
        cyc(2);
    endtask

    task automatic drive(input int per, input int n);
        for (int k = 0; k < n; k++) begin
            int p;
            p = (per == 0) ? (((k % 10) == 0) ? 7 : 6) : per;
            clk_in = 1'b1;
            cyc(p - p / 2);
            clk_in = 1'b0;
            cyc(p / 2);
        end
    endtask

    function automatic string vec_tag(input vec_t v);
        if (v.rate == 2'b11) return "R5";
        if (v.exp_lost)      return "R4";
        return "R1";
    endfunction

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int snap;
        // Reset state
        cyc(3);
        check("R6", "flag in reset", sig_lost, 1);
        check("R8", "use_ext in reset", use_ext, 0);
        check("R8", "tick in reset", ext_tick, 0);
        rst_n = 1'b1;
        cyc(2);
        check("R6", "flag after reset", sig_lost, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            start(VEC[i].rate);
            pulse_clr();
            drive(VEC[i].per, VEC[i].nper);
            check(vec_tag(VEC[i]), "flag after run", sig_lost, VEC[i].exp_lost);
            check("R8", "use_ext after run", use_ext, !VEC[i].exp_lost);
            pulse_clr();
            check("R6", "flag after clear", sig_lost, 0);
        end

        // R2: deselect forces the flag, clear ignored
        start(2'b01);
        pulse_clr();
        drive(4000, 2);
        check("R2", "flag before deselect", sig_lost, 0);
        ext_sel = 1'b0;
        cyc(1);
        check("R2", "flag after deselect", sig_lost, 1);
        check("R2", "use_ext after deselect", use_ext, 0);
        pulse_clr();
        check("R2", "clear while deselected", sig_lost, 1);

        // R3: stall threshold at two nominal periods
        start(2'b00);
        pulse_clr();
        drive(2000, 2);
        check("R3", "flag after good periods", sig_lost, 0);
        cyc(1700);
        check("R3", "flag short of stall", sig_lost, 0);
        cyc(400);
        check("R3", "flag after stall", sig_lost, 1);

        // R8: ticks only while qualified
        start(2'b00);
        pulse_clr();
        snap = tick_seen;
        drive(2000, 3);
        check("R8", "ticks while qualified", tick_seen - snap, 3);
        check("R8", "use_ext while qualified", use_ext, 1);
        start(2'b00);
        snap = tick_seen;
        drive(2000, 2);
        check("R8", "ticks while flagged", tick_seen - snap, 0);
        check("R8", "use_ext while flagged", use_ext, 0);

        // R9: rate change restarts the measurement
        start(2'b00);
        pulse_clr();
        drive(2000, 2);
        rate_sel = 2'b01;
        drive(4000, 3);
        check("R9", "flag after rate change", sig_lost, 0);

        // R7: clear on a bad verdict inhibits drift only
        start(2'b01);
        drive(3900, 2);
        check("R4", "flag after bad periods", sig_lost, 1);
        pulse_clr();
        check("R7", "flag after clear on bad", sig_lost, 0);
        drive(3900, 3);
        check("R7", "drift ignored while inhibited", sig_lost, 0);
        cyc(4300);
        check("R7", "stall still flagged", sig_lost, 1);
        start(2'b01);
        pulse_clr();
        drive(3900, 2);
        check("R7", "drift after inhibit release", sig_lost, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule